// File: doc/BRIEF.md
# Radix-N Nibble Compare and Decrement Unit

This execute unit serves a 4-bit processor. It handles the compare operations and the modulo-N memory decrement. Operands come from the A and B registers or from memory reached through the X and Y index registers. The fetch and decode stages hand it one operation per cycle, with these inputs:

- a 2-bit operation code;
- two operands, each 8 bits wide (nibble operations use only the low four bits);
- a post-increment request;
- a 4-bit radix.

One clock later the unit presents its results:

- the flag updates (zero and borrow) with their write strobe;
- up to two write-back nibbles, each with its own strobe;
- a strobe that tells the index register to step by one.

A compare only updates the flags. The radix decrement writes back `operand-1` and keeps the result inside 0..N-1, where a radix input of 0 stands for N = 16. The exchange operation writes each operand into the other's place and leaves the flags alone. An 8-bit compare of an index register against an immediate is also provided; it never steps the index.

Top module: `nrd_unit`

## Requirements
- R1: Results appear one clock after `in_valid`, and `out_valid` is high for exactly that cycle. Synchronous reset drives `out_valid` and every strobe low.
- R2: With `in_op`=0 (nibble compare), the unit computes `in_lhs[3:0]-in_rhs[3:0]`:
  - `out_zero` is set when the operands are equal;
  - `out_borrow` is set when `in_lhs[3:0] < in_rhs[3:0]`;
  - `out_flag_we` is high, and both write strobes are low.
- R3: With `in_op`=1 (index compare), the unit compares all 8 bits the same way as R2. Both write strobes stay low, and `out_idx_inc` stays low whatever `in_postinc` is.
- R4: With `in_op`=2 (radix decrement) and `in_lhs[3:0]`=0:
  - `out_lhs_data` is N-1;
  - `out_borrow` is 1;
  - `out_wr_lhs` and `out_flag_we` are high.
- R5: With `in_op`=2 and 0 < `in_lhs[3:0]` < N, `out_lhs_data` is the operand minus 1 and `out_borrow` is 0. `out_zero` is set exactly when the 4-bit result is 0.
- R6: An `in_radix` of 0 selects N = 16, which gives a plain 4-bit binary decrement that wraps from 0 to 15.
- R7: With `in_op`=2 and an operand at or above N, the unit first forms operand-1. If that value is still at least N, it then subtracts 16-N modulo 16.
- R8: With `in_op`=3 (exchange):
  - `out_lhs_data` = `in_rhs[3:0]`;
  - `out_rhs_data` = `in_lhs[3:0]`;
  - both write strobes are high, and `out_flag_we` is low.
- R9: For `in_op` 0, 2 and 3, `out_idx_inc` equals the `in_postinc` that was presented with the operation.
- R10: A cycle with `in_valid` low yields `out_valid`, `out_flag_we`, both write strobes and `out_idx_inc` all low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | 0 nibble compare, 1 index compare, 2 radix decrement, 3 exchange |
| in_postinc | input | 1 | Operand form steps its index register |
| in_lhs | input | 8 | First operand (low nibble for 4-bit operations) |
| in_rhs | input | 8 | Second operand (low nibble for 4-bit operations) |
| in_radix | input | 4 | Decrement radix, 0 meaning 16 |
| out_valid | output | 1 | Result cycle |
| out_flag_we | output | 1 | Update Z and C |
| out_zero | output | 1 | Zero flag value |
| out_borrow | output | 1 | Carry/borrow flag value |
| out_wr_lhs | output | 1 | Write `out_lhs_data` to the first operand location |
| out_lhs_data | output | 4 | Write-back nibble for the first operand |
| out_wr_rhs | output | 1 | Write `out_rhs_data` to the second operand location |
| out_rhs_data | output | 4 | Write-back nibble for the second operand |
| out_idx_inc | output | 1 | Increment the index register by one |

## Verification
The bench targets these corner cases:

- **Decrement from zero at a non-power-of-two radix.** A unit that wraps to 15 instead of N-1, or that forgets the borrow, would leave a decimal counter stuck at invalid digits.
- **Out-of-range operands.** A design that skips the correction step would write back values at or above N.
- **The radix-0 case.** A design that takes 0 literally would produce garbage there.
- **Post-increment on an index compare.** A design that honours the request would step X or Y wrongly.
- **Exchange.** A design that swaps the write-back lanes would be caught, as would one that lets the flags change.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    localparam int NW = 4;
    localparam int XW = 8;

    typedef enum logic [1:0] {
        OP_CMPN = 2'd0,
        OP_CMPX = 2'd1,
        OP_DECN = 2'd2,
        OP_SWAP = 2'd3
    } nrd_op_e;

    typedef struct packed {
        logic          valid;
        logic          flag_we;
        logic          zero;
        logic          borrow;
        logic          wr_lhs;
        logic [NW-1:0] lhs_data;
        logic          wr_rhs;
        logic [NW-1:0] rhs_data;
        logic          idx_inc;
    } nrd_res_t;

    // Effective modulus: a radix code of zero stands for 2**NW.
    function automatic logic [NW:0] radix_of(input logic [NW-1:0] code);
        logic [NW:0] full;
        full = {1'b1, {NW{1'b0}}};
        return (code == '0) ? full : {1'b0, code};
    endfunction

endpackage

// File: rtl/nrd_cmp.sv
module nrd_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         zero,
    output logic         borrow
);
    logic [W:0] diff;

    always_comb begin
        diff   = {1'b0, a} - {1'b0, b};
        borrow = diff[W];
        zero   = (diff[W-1:0] == '0);
    end
endmodule

// File: rtl/nrd_rdec.sv
module nrd_rdec
    import nrd_pkg::*;
(
    input  logic [NW-1:0] val,
    input  logic [NW-1:0] radix,
    output logic [NW-1:0] res,
    output logic          zero,
    output logic          borrow
);
    logic [NW:0]   modn;
    logic [NW:0]   gap;
    logic [NW-1:0] step;

    always_comb begin
        modn = radix_of(radix);
        gap  = {1'b1, {NW{1'b0}}} - modn;
        step = val - NW'(1);
        if (val == '0) begin
            res    = NW'(modn - (NW+1)'(1));
            borrow = 1'b1;
        end else begin
            borrow = 1'b0;
            if ({1'b0, step} >= modn)
                res = step - gap[NW-1:0];
            else
                res = step;
        end
        zero = (res == '0);
    end
endmodule

// File: rtl/nrd_sel.sv
module nrd_sel
    import nrd_pkg::*;
(
    input  logic          valid,
    input  nrd_op_e       op,
    input  logic          postinc,
    input  logic [NW-1:0] lhs,
    input  logic [NW-1:0] rhs,
    input  logic          cn_zero,
    input  logic          cn_borrow,
    input  logic          cx_zero,
    input  logic          cx_borrow,
    input  logic [NW-1:0] dec_res,
    input  logic          dec_zero,
    input  logic          dec_borrow,
    output nrd_res_t      res
);
    always_comb begin
        res       = '0;
        res.valid = valid;
        if (valid) begin
            unique case (op)
                OP_CMPN: begin
                    res.flag_we = 1'b1;
                    res.zero    = cn_zero;
                    res.borrow  = cn_borrow;
                    res.idx_inc = postinc;
                end
                OP_CMPX: begin
                    res.flag_we = 1'b1;
                    res.zero    = cx_zero;
                    res.borrow  = cx_borrow;
                end
                OP_DECN: begin
                    res.flag_we  = 1'b1;
                    res.zero     = dec_zero;
                    res.borrow   = dec_borrow;
                    res.wr_lhs   = 1'b1;
                    res.lhs_data = dec_res;
                    res.idx_inc  = postinc;
                end
                OP_SWAP: begin
                    res.wr_lhs   = 1'b1;
                    res.lhs_data = rhs;
                    res.wr_rhs   = 1'b1;
                    res.rhs_data = lhs;
                    res.idx_inc  = postinc;
                end
                default: res = '0;
            endcase
        end
    end
endmodule

// File: rtl/nrd_unit.sv
module nrd_unit
    import nrd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic          in_postinc,
    input  logic [XW-1:0] in_lhs,
    input  logic [XW-1:0] in_rhs,
    input  logic [NW-1:0] in_radix,
    output logic          out_valid,
    output logic          out_flag_we,
    output logic          out_zero,
    output logic          out_borrow,
    output logic          out_wr_lhs,
    output logic [NW-1:0] out_lhs_data,
    output logic          out_wr_rhs,
    output logic [NW-1:0] out_rhs_data,
    output logic          out_idx_inc
);
    nrd_op_e       op;
    logic          cn_zero, cn_borrow, cx_zero, cx_borrow;
    logic [NW-1:0] dec_res;
    logic          dec_zero, dec_borrow;
    nrd_res_t      nxt, cur;

    assign op = nrd_op_e'(in_op);

    nrd_cmp #(.W(NW)) u_cmpn (
        .a(in_lhs[NW-1:0]), .b(in_rhs[NW-1:0]),
        .zero(cn_zero), .borrow(cn_borrow)
    );

    nrd_cmp #(.W(XW)) u_cmpx (
        .a(in_lhs), .b(in_rhs),
        .zero(cx_zero), .borrow(cx_borrow)
    );

    nrd_rdec u_rdec (
        .val(in_lhs[NW-1:0]), .radix(in_radix),
        .res(dec_res), .zero(dec_zero), .borrow(dec_borrow)
    );

    nrd_sel u_sel (
        .valid(in_valid), .op(op), .postinc(in_postinc),
        .lhs(in_lhs[NW-1:0]), .rhs(in_rhs[NW-1:0]),
        .cn_zero(cn_zero), .cn_borrow(cn_borrow),
        .cx_zero(cx_zero), .cx_borrow(cx_borrow),
        .dec_res(dec_res), .dec_zero(dec_zero), .dec_borrow(dec_borrow),
        .res(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign out_valid    = cur.valid;
    assign out_flag_we  = cur.flag_we;
    assign out_zero     = cur.zero;
    assign out_borrow   = cur.borrow;
    assign out_wr_lhs   = cur.wr_lhs;
    assign out_lhs_data = cur.lhs_data;
    assign out_wr_rhs   = cur.wr_rhs;
    assign out_rhs_data = cur.rhs_data;
    assign out_idx_inc  = cur.idx_inc;
endmodule

// File: rtl/nrd_unit_chk.sv
module nrd_unit_chk
    import nrd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic          in_postinc,
    input logic [XW-1:0] in_lhs,
    input logic [XW-1:0] in_rhs,
    input logic [NW-1:0] in_radix,
    input logic          out_valid,
    input logic          out_flag_we,
    input logic          out_zero,
    input logic          out_borrow,
    input logic          out_wr_lhs,
    input logic [NW-1:0] out_lhs_data,
    input logic          out_wr_rhs,
    input logic [NW-1:0] out_rhs_data,
    input logic          out_idx_inc
);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_flag_we && !out_wr_lhs && !out_wr_rhs && !out_idx_inc));

    p_cmp_flags_only_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0) |=> (out_valid && out_flag_we && !out_wr_lhs && !out_wr_rhs));

    p_cmpx_no_step_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1) |=> (out_flag_we && !out_idx_inc && !out_wr_lhs && !out_wr_rhs));

    p_dec_zero_borrows_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2 && in_lhs[NW-1:0] == '0) |=> (out_borrow && out_wr_lhs));

    p_dec_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2 && in_radix != '0 && in_lhs[NW-1:0] < in_radix)
        |=> (out_lhs_data < $past(in_radix)));

    p_swap_lanes_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=> (!out_flag_we && out_wr_lhs && out_wr_rhs
            && out_lhs_data == $past(in_rhs[NW-1:0]) && out_rhs_data == $past(in_lhs[NW-1:0])));

    p_step_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'd1) |=> (out_idx_inc == $past(in_postinc)));
endmodule

bind nrd_unit nrd_unit_chk u_chk (.*);

// File: tb/nrd_unit_test.sv
module nrd_unit_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [1:0] in_op;
    logic       in_postinc;
    logic [7:0] in_lhs, in_rhs;
    logic [3:0] in_radix;
    logic       out_valid, out_flag_we, out_zero, out_borrow;
    logic       out_wr_lhs, out_wr_rhs, out_idx_inc;
    logic [3:0] out_lhs_data, out_rhs_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nrd_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_postinc(in_postinc), .in_lhs(in_lhs), .in_rhs(in_rhs),
        .in_radix(in_radix), .out_valid(out_valid), .out_flag_we(out_flag_we),
        .out_zero(out_zero), .out_borrow(out_borrow), .out_wr_lhs(out_wr_lhs),
        .out_lhs_data(out_lhs_data), .out_wr_rhs(out_wr_rhs),
        .out_rhs_data(out_rhs_data), .out_idx_inc(out_idx_inc)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one operation at a falling edge; results are registered at the
    // next rising edge and read at the following falling edge.
    task automatic issue(input logic [1:0] op, input logic pi,
                         input logic [7:0] a, input logic [7:0] b, input logic [3:0] rad);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_postinc = pi;
        in_lhs = a; in_rhs = b; in_radix = rad;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 valid after reset", out_valid, 0);
        check("R1 strobes after reset", {out_flag_we, out_wr_lhs, out_wr_rhs, out_idx_inc}, 0);
    endtask

    task automatic t_cmpn(input logic [3:0] a, input logic [3:0] b, input logic pi);
        issue(2'd0, pi, {4'hA, a}, {4'h5, b}, 4'd0);
        check("R2 valid", out_valid, 1);
        check("R2 flag_we", out_flag_we, 1);
        check("R2 zero", out_zero, (a == b) ? 1 : 0);
        check("R2 borrow", out_borrow, (a < b) ? 1 : 0);
        check("R2 no write", {out_wr_lhs, out_wr_rhs}, 0);
        check("R9 idx_inc cmpn", out_idx_inc, pi);
    endtask

    task automatic t_cmpx(input logic [7:0] a, input logic [7:0] b);
        issue(2'd1, 1'b1, a, b, 4'd0);
        check("R3 zero", out_zero, (a == b) ? 1 : 0);
        check("R3 borrow", out_borrow, (a < b) ? 1 : 0);
        check("R3 no write", {out_wr_lhs, out_wr_rhs}, 0);
        check("R3 idx_inc ignored", out_idx_inc, 0);
    endtask

    task automatic t_dec(input string tag, input logic [3:0] v, input logic [3:0] rad,
                         input int exp_res, input int exp_c, input logic pi);
        issue(2'd2, pi, {4'hF, v}, 8'h00, rad);
        check({tag, " result"}, out_lhs_data, exp_res);
        check({tag, " borrow"}, out_borrow, exp_c);
        check({tag, " zero"}, out_zero, (exp_res == 0) ? 1 : 0);
        check({tag, " write/flags"}, {out_wr_lhs, out_flag_we, out_wr_rhs}, 3'b110);
        check("R9 idx_inc dec", out_idx_inc, pi);
    endtask

    task automatic t_swap;
        issue(2'd3, 1'b1, 8'h73, 8'h6C, 4'd0);
        check("R8 lhs_data", out_lhs_data, 12);
        check("R8 rhs_data", out_rhs_data, 3);
        check("R8 strobes", {out_wr_lhs, out_wr_rhs, out_flag_we}, 3'b110);
        check("R9 idx_inc swap", out_idx_inc, 1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R10 quiet", {out_valid, out_flag_we, out_wr_lhs, out_wr_rhs, out_idx_inc}, 0);
        @(negedge clk);
        check("R1 single-cycle valid", out_valid, 0);
    endtask

    initial begin
        fork
            begin
                rst = 1'b1; in_valid = 1'b0; in_op = 2'd0; in_postinc = 1'b0;
                in_lhs = '0; in_rhs = '0; in_radix = '0;
                repeat (3) @(posedge clk);
                @(negedge clk) rst = 1'b0;
                t_reset();
                t_cmpn(4'd5, 4'd3, 1'b0);
                t_cmpn(4'd3, 4'd5, 1'b1);
                t_cmpn(4'd7, 4'd7, 1'b0);
                t_cmpx(8'h80, 8'h80);
                t_cmpx(8'h10, 8'hFF);
                t_cmpx(8'hF0, 8'h0F);
                t_dec("R4 dec 0 N=10", 4'd0, 4'd10, 9, 1, 1'b1);
                t_dec("R4 dec 0 N=3", 4'd0, 4'd3, 2, 1, 1'b0);
                t_dec("R5 dec 5 N=10", 4'd5, 4'd10, 4, 0, 1'b0);
                t_dec("R5 dec 1 N=10", 4'd1, 4'd10, 0, 0, 1'b1);
                t_dec("R5 dec 9 N=10", 4'd9, 4'd10, 8, 0, 1'b0);
                t_dec("R6 dec 0 N=16", 4'd0, 4'd0, 15, 1, 1'b0);
                t_dec("R6 dec 8 N=16", 4'd8, 4'd0, 7, 0, 1'b0);
                t_dec("R7 dec 15 N=10", 4'd15, 4'd10, 8, 0, 1'b0);
                t_dec("R7 dec 12 N=10", 4'd12, 4'd10, 5, 0, 1'b0);
                t_dec("R7 dec 10 N=10", 4'd10, 4'd10, 9, 0, 1'b0);
                t_swap();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule